// File: doc/BRIEF.md
# Transaction Queue Slot Controller

This block is one slot of a cache miss-handling transaction queue. A core request claims the slot at the same time as it enters the cache lookup pipeline, so the claim is speculative. While it is claimed, the slot holds the request's cache line address, word offset, destination register tag and access kind (read or write).

The slot then follows the lookup result. On a hit it releases itself and drops what it holds. It does not release while the lookup reports that a younger request to the same line is still in flight. On a miss it waits for the far-memory read response. It then asks to send a fill into the lookup pipeline and releases itself when that fill is granted. A fill always allocates, so no lookup result is awaited after the grant.

Lookup and far-memory responses carry a slot tag, and the slot reacts only to responses tagged with its own identifier. Any event that does not fit the current state parks the slot in a sticky error state, and only reset clears it. Besides the slot's state and contents, the outputs give a free flag, a fill-request flag and two flags that mark a new read or write to the line the slot holds.

Top module: `txq_slot`

## Requirements
- R1: After a synchronous active-high reset:
  - the state output is IDLE (code 0);
  - `slot_free` is 1;
  - `fill_req` is 0;
  - the read and write kind flags, the stored fields and both line-match flags are 0.
- R2: In IDLE, `alloc` together with `req_valid` moves the state to LOOKUP (code 1) one cycle later. In the same cycle the slot stores `req_line`, `req_ofs` and `req_tag`, and sets `kind_wr` = `req_is_wr` and `kind_rd` = not `req_is_wr`. `alloc` without `req_valid` in IDLE has no effect.
- R3: In LOOKUP, an own-tagged lookup response with `lu_hit`=1 and `lu_line_pend`=0 returns the slot to IDLE. The stored fields and kind flags are cleared.
- R4: In LOOKUP, an own-tagged hit with `lu_line_pend`=1 keeps the slot in LOOKUP, with its contents unchanged.
- R5: In LOOKUP, an own-tagged response with `lu_hit`=0 moves the slot to WAIT_FILL (code 2).
- R6: In WAIT_FILL, an own-tagged far-memory response moves the slot to FILL_READY (code 3). `fill_req` is 1 exactly when the state is FILL_READY.
- R7: In FILL_READY, `fill_grant` returns the slot to IDLE one cycle later, with no lookup response needed.
- R8: Lookup and far-memory responses whose tag differs from `slot_id` have no effect on the state.
- R9: `cancel` in LOOKUP returns the slot to IDLE and takes priority over a lookup response in the same cycle. In WAIT_FILL or FILL_READY, `cancel` has no effect.
- R10: The slot enters ERROR (code 7) on any of these events:
  - an own-tagged lookup response outside LOOKUP;
  - an own-tagged far-memory response outside WAIT_FILL;
  - `fill_grant` outside FILL_READY;
  - `alloc` outside IDLE.

  ERROR is left only by reset.
- R11: One cycle after a cycle with `req_valid`=1 in LOOKUP, WAIT_FILL or FILL_READY, where `req_line` equals the stored line:
  - `line_wr_hit` is 1 for a write (`req_is_wr`=1);
  - `line_rd_hit` is 1 for a read.

  Otherwise both flags are 0 after that cycle.
- R12: `slot_free` is 1 exactly when the state is IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_id | input | ID_W (3) | Tag of this slot |
| req_valid | input | 1 | Core request present |
| req_is_wr | input | 1 | Request kind: 1 write, 0 read |
| req_line | input | LINE_W (16) | Cache line address of the request |
| req_ofs | input | OFS_W (2) | Word offset within the line |
| req_tag | input | TAG_W (6) | Destination register tag |
| alloc | input | 1 | Claim this slot for the current request |
| lu_valid | input | 1 | Lookup response present |
| lu_id | input | ID_W (3) | Slot tag of the lookup response |
| lu_hit | input | 1 | Lookup result: 1 hit, 0 miss |
| lu_line_pend | input | 1 | Another request to the same line is still in the lookup pipeline |
| fm_valid | input | 1 | Far-memory read response present |
| fm_id | input | ID_W (3) | Slot tag of the far-memory response |
| fill_grant | input | 1 | This slot's fill won arbitration |
| cancel | input | 1 | Abort the pending core request |
| state_o | output | 3 | Slot state code |
| line_o | output | LINE_W (16) | Stored line address |
| ofs_o | output | OFS_W (2) | Stored word offset |
| tag_o | output | TAG_W (6) | Stored register tag |
| kind_rd | output | 1 | Stored request is a read |
| kind_wr | output | 1 | Stored request is a write |
| line_rd_hit | output | 1 | A read to the stored line was seen |
| line_wr_hit | output | 1 | A write to the stored line was seen |
| slot_free | output | 1 | Slot is free |
| fill_req | output | 1 | Slot requests fill issue |

## Verification
The bench sweeps several line, offset and tag patterns for both request kinds. This separates correct capture from swapped or stuck fields and from inverted read/write flags. Lookup responses cover all three combinations of hit and line-pending, which distinguishes a release from a held slot and from a miss. Responses carrying every other slot tag confirm that only the slot's own tag is acted on.

Each combination of state and out-of-place event is applied on its own, which shows exactly which events in which states enter the sticky error state. Same-line and different-line requests in busy and idle states separate the two line-match flags from each other and from state gating.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_LOOKUP    = 3'd1,
    ST_WAIT_FILL = 3'd2,
    ST_FILL_RDY  = 3'd3,
    ST_ERROR     = 3'd7
  } slot_state_t;
endpackage

// File: rtl/txq_evt_decode.sv
module txq_evt_decode #(
  parameter int ID_W = 3
) (
  input  logic [ID_W-1:0] slot_id,
  input  logic            lu_valid,
  input  logic [ID_W-1:0] lu_id,
  input  logic            fm_valid,
  input  logic [ID_W-1:0] fm_id,
  output logic            lu_mine,
  output logic            fm_mine
);
  always_comb begin
    lu_mine = lu_valid && (lu_id == slot_id);
    fm_mine = fm_valid && (fm_id == slot_id);
  end
endmodule

// File: rtl/txq_fsm.sv
module txq_fsm
  import txq_pkg::*;
(
  input  slot_state_t cur,
  input  logic        req_valid,
  input  logic        alloc,
  input  logic        lu_mine,
  input  logic        lu_hit,
  input  logic        lu_line_pend,
  input  logic        fm_mine,
  input  logic        fill_grant,
  input  logic        cancel,
  output slot_state_t nxt
);
  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_IDLE: begin
        if (lu_mine || fm_mine || fill_grant) nxt = ST_ERROR;
        else if (alloc && req_valid)          nxt = ST_LOOKUP;
      end
      ST_LOOKUP: begin
        if (fm_mine || fill_grant || alloc) nxt = ST_ERROR;
        else if (cancel)                    nxt = ST_IDLE;
        else if (lu_mine) begin
          if (!lu_hit)           nxt = ST_WAIT_FILL;
          else if (!lu_line_pend) nxt = ST_IDLE;
        end
      end
      ST_WAIT_FILL: begin
        if (lu_mine || fill_grant || alloc) nxt = ST_ERROR;
        else if (fm_mine)                   nxt = ST_FILL_RDY;
      end
      ST_FILL_RDY: begin
        if (lu_mine || fm_mine || alloc) nxt = ST_ERROR;
        else if (fill_grant)             nxt = ST_IDLE;
      end
      default: nxt = ST_ERROR;
    endcase
  end
endmodule

// File: rtl/txq_fields.sv
module txq_fields
  import txq_pkg::*;
#(
  parameter int LINE_W = 16,
  parameter int OFS_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  slot_state_t       cur,
  input  slot_state_t       nxt,
  input  logic              req_valid,
  input  logic              req_is_wr,
  input  logic [LINE_W-1:0] req_line,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [TAG_W-1:0]  req_tag,
  output logic [LINE_W-1:0] line_q,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic              rd_q,
  output logic              wr_q,
  output logic              rd_hit_q,
  output logic              wr_hit_q
);
  logic load, clear, busy, same_line;

  always_comb begin
    load      = (cur == ST_IDLE) && (nxt == ST_LOOKUP);
    clear     = (nxt == ST_IDLE);
    busy      = (cur == ST_LOOKUP) || (cur == ST_WAIT_FILL) || (cur == ST_FILL_RDY);
    same_line = busy && req_valid && (req_line == line_q);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      line_q <= '0;
      ofs_q  <= '0;
      tag_q  <= '0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
    end else if (load) begin
      line_q <= req_line;
      ofs_q  <= req_ofs;
      tag_q  <= req_tag;
      rd_q   <= !req_is_wr;
      wr_q   <= req_is_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit_q <= 1'b0;
      wr_hit_q <= 1'b0;
    end else begin
      rd_hit_q <= same_line && !req_is_wr;
      wr_hit_q <= same_line && req_is_wr;
    end
  end
endmodule

// File: rtl/txq_slot.sv
module txq_slot
  import txq_pkg::*;
#(
  parameter int ID_W   = 3,
  parameter int LINE_W = 16,
  parameter int OFS_W  = 2,
  parameter int TAG_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   slot_id,
  input  logic              req_valid,
  input  logic              req_is_wr,
  input  logic [LINE_W-1:0] req_line,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              alloc,
  input  logic              lu_valid,
  input  logic [ID_W-1:0]   lu_id,
  input  logic              lu_hit,
  input  logic              lu_line_pend,
  input  logic              fm_valid,
  input  logic [ID_W-1:0]   fm_id,
  input  logic              fill_grant,
  input  logic              cancel,
  output logic [2:0]        state_o,
  output logic [LINE_W-1:0] line_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic              kind_rd,
  output logic              kind_wr,
  output logic              line_rd_hit,
  output logic              line_wr_hit,
  output logic              slot_free,
  output logic              fill_req
);
  slot_state_t st_q, st_n;
  logic        lu_mine, fm_mine;
  logic        free_q, fill_q;

  txq_evt_decode #(.ID_W(ID_W)) u_dec (
    .slot_id (slot_id),
    .lu_valid(lu_valid),
    .lu_id   (lu_id),
    .fm_valid(fm_valid),
    .fm_id   (fm_id),
    .lu_mine (lu_mine),
    .fm_mine (fm_mine)
  );

  txq_fsm u_fsm (
    .cur         (st_q),
    .req_valid   (req_valid),
    .alloc       (alloc),
    .lu_mine     (lu_mine),
    .lu_hit      (lu_hit),
    .lu_line_pend(lu_line_pend),
    .fm_mine     (fm_mine),
    .fill_grant  (fill_grant),
    .cancel      (cancel),
    .nxt         (st_n)
  );

  txq_fields #(.LINE_W(LINE_W), .OFS_W(OFS_W), .TAG_W(TAG_W)) u_fields (
    .clk      (clk),
    .rst      (rst),
    .cur      (st_q),
    .nxt      (st_n),
    .req_valid(req_valid),
    .req_is_wr(req_is_wr),
    .req_line (req_line),
    .req_ofs  (req_ofs),
    .req_tag  (req_tag),
    .line_q   (line_o),
    .ofs_q    (ofs_o),
    .tag_q    (tag_o),
    .rd_q     (kind_rd),
    .wr_q     (kind_wr),
    .rd_hit_q (line_rd_hit),
    .wr_hit_q (line_wr_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      free_q <= 1'b1;
      fill_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      free_q <= (st_n == ST_IDLE);
      fill_q <= (st_n == ST_FILL_RDY);
    end
  end

  assign state_o   = st_q;
  assign slot_free = free_q;
  assign fill_req  = fill_q;
endmodule

// File: rtl/txq_slot_chk.sv
module txq_slot_chk #(
  parameter int ID_W   = 3,
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ID_W-1:0]   slot_id,
  input logic              req_valid,
  input logic [LINE_W-1:0] req_line,
  input logic              alloc,
  input logic              lu_valid,
  input logic [ID_W-1:0]   lu_id,
  input logic              lu_hit,
  input logic              lu_line_pend,
  input logic              fm_valid,
  input logic [ID_W-1:0]   fm_id,
  input logic              fill_grant,
  input logic              cancel,
  input logic [2:0]        state_o,
  input logic [LINE_W-1:0] line_o,
  input logic              slot_free,
  input logic              fill_req
);
  logic lu_m, fm_m;
  assign lu_m = lu_valid && (lu_id == slot_id);
  assign fm_m = fm_valid && (fm_id == slot_id);

  assert_free_idle_R12: assert property (@(posedge clk) disable iff (rst)
    slot_free == (state_o == 3'd0));

  assert_fill_ready_R6: assert property (@(posedge clk) disable iff (rst)
    fill_req == (state_o == 3'd3));

  assert_error_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd7) |=> (state_o == 3'd7));

  assert_alloc_enter_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd0 && alloc && req_valid && !lu_m && !fm_m && !fill_grant)
      |=> (state_o == 3'd1 && line_o == $past(req_line)));

  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && lu_m && lu_hit && lu_line_pend && !cancel && !fm_m &&
     !fill_grant && !alloc) |=> (state_o == 3'd1));

  assert_grant_release_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && fill_grant && !lu_m && !fm_m && !alloc) |=> slot_free);

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (rst)
    state_o inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd7});
endmodule

bind txq_slot txq_slot_chk #(.ID_W(ID_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .slot_id(slot_id), .req_valid(req_valid),
  .req_line(req_line), .alloc(alloc), .lu_valid(lu_valid), .lu_id(lu_id),
  .lu_hit(lu_hit), .lu_line_pend(lu_line_pend), .fm_valid(fm_valid),
  .fm_id(fm_id), .fill_grant(fill_grant), .cancel(cancel),
  .state_o(state_o), .line_o(line_o), .slot_free(slot_free), .fill_req(fill_req)
);

// File: tb/tb_txq_slot.sv
`timescale 1ns/1ps
module tb_txq_slot;
  localparam logic [2:0] MY_ID = 3'd5;

  logic clk = 0, rst = 1;
  logic [2:0]  slot_id = MY_ID;
  logic req_valid = 0, req_is_wr = 0, alloc = 0;
  logic [15:0] req_line = 0;
  logic [1:0]  req_ofs = 0;
  logic [5:0]  req_tag = 0;
  logic lu_valid = 0, lu_hit = 0, lu_line_pend = 0, fm_valid = 0;
  logic [2:0] lu_id = 0, fm_id = 0;
  logic fill_grant = 0, cancel = 0;
  logic [2:0]  state_o;
  logic [15:0] line_o;
  logic [1:0]  ofs_o;
  logic [5:0]  tag_o;
  logic kind_rd, kind_wr, line_rd_hit, line_wr_hit, slot_free, fill_req;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  txq_slot dut (.*);

  task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic quiet();
    req_valid = 0; alloc = 0; lu_valid = 0; fm_valid = 0;
    fill_grant = 0; cancel = 0; lu_hit = 0; lu_line_pend = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    quiet();
  endtask

  task automatic do_reset();
    quiet(); rst = 1; step(); rst = 0;
  endtask

  task automatic do_alloc(logic wr, logic [15:0] ln, logic [1:0] of, logic [5:0] tg);
    req_valid = 1; alloc = 1; req_is_wr = wr; req_line = ln; req_ofs = of; req_tag = tg;
    step();
  endtask

  task automatic do_lu(logic [2:0] id, logic h, logic p);
    lu_valid = 1; lu_id = id; lu_hit = h; lu_line_pend = p; step();
  endtask

  task automatic do_fm(logic [2:0] id);
    fm_valid = 1; fm_id = id; step();
  endtask

  task automatic goto_state(int s);
    do_reset();
    if (s >= 1) do_alloc(1'b1, 16'h1234, 2'd1, 6'd9);
    if (s >= 2) do_lu(MY_ID, 1'b0, 1'b0);
    if (s >= 3) do_fm(MY_ID);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 state", state_o, 0);      chk("R1 free", slot_free, 1);
    chk("R1 fill", fill_req, 0);      chk("R1 kind", {kind_rd, kind_wr}, 0);
    chk("R1 fields", {line_o, ofs_o, tag_o}, 0);
    chk("R1 hits", {line_rd_hit, line_wr_hit}, 0);

    // R2 alloc without request ignored
    alloc = 1; step();
    chk("R2 alloc-no-req", state_o, 0);

    // Sweep patterns and kinds through hit/pend/miss paths
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 2; k++) begin
        logic [15:0] ln;
        ln = 16'h8001 ^ (16'h1111 * p[15:0]) ^ {15'd0, k[0]};
        do_reset();
        do_alloc(k[0], ln, p[1:0], 6'(p * 13 + k));
        chk("R2 state", state_o, 1);
        chk("R2 line", line_o, ln);
        chk("R2 ofs", ofs_o, p);
        chk("R2 tag", tag_o, p * 13 + k);
        chk("R2 kind", {kind_rd, kind_wr}, k[0] ? 2'b01 : 2'b10);
        chk("R12 busy", slot_free, 0);
        for (int i = 0; i < 8; i++) begin
          if (i[2:0] != MY_ID) begin
            do_lu(i[2:0], 1'b0, 1'b0);
            chk("R8 lu other id", state_o, 1);
          end
        end
        do_lu(MY_ID, 1'b1, 1'b1);
        chk("R4 pend hold", state_o, 1);
        chk("R4 line kept", line_o, ln);
        if (p[0]) begin
          do_lu(MY_ID, 1'b1, 1'b0);
          chk("R3 release", state_o, 0);
          chk("R3 cleared", {line_o, kind_rd, kind_wr}, 0);
          chk("R12 free", slot_free, 1);
        end else begin
          do_lu(MY_ID, 1'b0, 1'b0);
          chk("R5 miss", state_o, 2);
          for (int i = 0; i < 8; i++) begin
            if (i[2:0] != MY_ID) begin
              do_fm(i[2:0]);
              chk("R8 fm other id", state_o, 2);
            end
          end
          cancel = 1; step();
          chk("R9 cancel ignored wait", state_o, 2);
          // R11 line match flags
          req_valid = 1; req_is_wr = 1; req_line = ln; step();
          chk("R11 wr match", {line_rd_hit, line_wr_hit}, 2'b01);
          req_valid = 1; req_is_wr = 0; req_line = ln; step();
          chk("R11 rd match", {line_rd_hit, line_wr_hit}, 2'b10);
          req_valid = 1; req_is_wr = 1; req_line = ~ln; step();
          chk("R11 other line", {line_rd_hit, line_wr_hit}, 2'b00);
          step();
          chk("R11 no req", {line_rd_hit, line_wr_hit}, 2'b00);
          do_fm(MY_ID);
          chk("R6 ready", state_o, 3);
          chk("R6 fill", fill_req, 1);
          cancel = 1; step();
          chk("R9 cancel ignored ready", state_o, 3);
          fill_grant = 1; step();
          chk("R7 grant", state_o, 0);
          chk("R7 free", slot_free, 1);
          chk("R6 fill off", fill_req, 0);
          req_valid = 1; req_is_wr = 1; req_line = 16'h0; step();
          chk("R11 idle no match", {line_rd_hit, line_wr_hit}, 0);
        end
      end
    end

    // R9 cancel in lookup beats a same-cycle lookup miss
    goto_state(1);
    cancel = 1; lu_valid = 1; lu_id = MY_ID; lu_hit = 0; step();
    chk("R9 cancel lookup", state_o, 0);
    chk("R9 free", slot_free, 1);

    // R10 out-of-place events per state
    for (int s = 0; s < 4; s++) begin
      for (int e = 0; e < 4; e++) begin
        if (!((s == 0 && e == 3) || (s == 1 && e == 0) ||
              (s == 2 && e == 1) || (s == 3 && e == 2))) begin
          goto_state(s);
          case (e)
            0: begin lu_valid = 1; lu_id = MY_ID; lu_hit = 1; end
            1: begin fm_valid = 1; fm_id = MY_ID; end
            2: fill_grant = 1;
            default: begin alloc = 1; req_valid = 1; end
          endcase
          step();
          chk("R10 enter error", state_o, 7);
          chk("R10 not free", slot_free, 0);
          fill_grant = 1; cancel = 1; step();
          chk("R10 sticky", state_o, 7);
          do_reset();
          chk("R10 reset exit", state_o, 0);
        end
      end
    end
    finish_run();
  end
endmodule